// File: doc/BRIEF.md
# Phase-Offset Programmable Clock Divider

The block divides a fast input clock by an integer ratio picked from one of two fixed tables. Two four-level strap codes form a 4-bit index, and a table-select input chooses between a default table and an alternate one. Even ratios produce a 50% duty cycle. Odd ratios produce a high time that is one input cycle shorter than the low time. A ratio of one bypasses the counter, and the input clock reaches the output through a glitch-free gate.

A synchronization request holds the output low and clears the counters. On that same edge the block captures the strap codes, the table select and a 4-bit phase word. After the request is released, the divider waits the captured number of input cycles before its first high phase. Several dividers released by one common sync therefore have output-to-output skews that are set in steps of one input period. A change to the configuration inputs has no effect until the next sync. A running flag shows that the divider has been released.

Top module: `phase_clk_div`

## Requirements
- R1: With table_sel_i=0, index = strap_hi_i*4 + strap_lo_i (strap_lo_i varies fastest) selects the ratio from 1,2,3,4,5,6,8,9,10,12,15,16,18,24,30,32 for index 0..15.
- R2: With table_sel_i=1, the same index selects the ratio from 7,11,13,14,17,19,20,21,22,23,25,26,27,28,29,31.
- R3: For an even ratio N ≥ 2, every period is N input cycles long: N/2 high cycles followed by N/2 low cycles.
- R4: For an odd ratio N ≥ 3, every period is N input cycles long: (N-1)/2 high cycles followed by (N+1)/2 low cycles.
- R5: Let E0 be the first rising edge of clk_i at which sync_i is sampled low after being sampled high. The divided output stays low through edges E0..E0+P-1, where P is the phase word captured at sync, and goes high at edge E0+P.
- R6: A phase word P of N or more still delays the first edge by P cycles. In steady state this gives the same phase as P mod N.
- R7: On every edge at which sync_i is sampled high, clk_o (for ratios above 1) and running_o go low from that edge on, and the period counter restarts.
- R8: With ratio 1, clk_o equals clk_i from the falling edge that follows E0, and the phase word is ignored. After a new sync, the gate closes on the following falling edge.
- R9: Changes to the strap codes, table_sel_i or phase_i while sync_i is low do not change the running output.
- R10: running_o rises at E0 and stays high until the next edge at which sync_i is sampled high.
- R11: While rst_ni is low, clk_o and running_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Active-high synchronization request |
| strap_lo_i | input | 2 | First strap level code (0,1/3,2/3,1 as 0..3) |
| strap_hi_i | input | 2 | Second strap level code |
| table_sel_i | input | 1 | 0 selects the default ratio table, 1 the alternate table |
| phase_i | input | 4 | Phase offset in input cycles, 0..15 |
| clk_o | output | 1 | Divided or bypassed clock |
| running_o | output | 1 | Divider released and running |

## Verification
The bench runs every entry of both tables with phase words of 0, 5 and 15. It also uses a phase word equal to the ratio whenever the ratio is 15 or less, which covers the wrap case. It checks the output against a reference model on both clock edges, and a first-edge delay that is off by one cycle shows up as a mismatch at E0+P. An odd ratio given a symmetric high time, or a counter that wraps one cycle early or late, shows up within one period as a wrong high count. The bench also changes the straps and the phase word in the middle of a run. A design that failed to hold the captured configuration would change its period there. Ratio-1 runs check both clock levels, which exposes a gate that is left open or that opens on the wrong edge.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int unsigned STRAP_W = 2;
  localparam int unsigned IDX_W   = 2 * STRAP_W;
  localparam int unsigned RATIO_W = 6;

  function automatic logic [RATIO_W-1:0] ratio_lookup(input logic alt, input logic [IDX_W-1:0] idx);
    logic [RATIO_W-1:0] r;
    case ({alt, idx})
      5'd0:  r = 6'd1;   5'd1:  r = 6'd2;   5'd2:  r = 6'd3;   5'd3:  r = 6'd4;
      5'd4:  r = 6'd5;   5'd5:  r = 6'd6;   5'd6:  r = 6'd8;   5'd7:  r = 6'd9;
      5'd8:  r = 6'd10;  5'd9:  r = 6'd12;  5'd10: r = 6'd15;  5'd11: r = 6'd16;
      5'd12: r = 6'd18;  5'd13: r = 6'd24;  5'd14: r = 6'd30;  5'd15: r = 6'd32;
      5'd16: r = 6'd7;   5'd17: r = 6'd11;  5'd18: r = 6'd13;  5'd19: r = 6'd14;
      5'd20: r = 6'd17;  5'd21: r = 6'd19;  5'd22: r = 6'd20;  5'd23: r = 6'd21;
      5'd24: r = 6'd22;  5'd25: r = 6'd23;  5'd26: r = 6'd25;  5'd27: r = 6'd26;
      5'd28: r = 6'd27;  5'd29: r = 6'd28;  5'd30: r = 6'd29;  default: r = 6'd31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pcd_cfg.sv
module pcd_cfg
  import pcd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_i,
  input  logic [STRAP_W-1:0] strap_lo_i,
  input  logic [STRAP_W-1:0] strap_hi_i,
  input  logic               table_sel_i,
  output logic [RATIO_W-1:0] ratio_o
);
  logic [RATIO_W-1:0] ratio_q;

  // configuration captured only while sync is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ratio_q <= RATIO_W'(2);
    else if (sync_i) ratio_q <= ratio_lookup(table_sel_i, {strap_hi_i, strap_lo_i});
  end

  assign ratio_o = ratio_q;

  a_r1_ratio_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_q != '0) && (ratio_q <= RATIO_W'(32)));

  a_r9_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> $stable(ratio_q));
endmodule

// File: rtl/pcd_core.sv
module pcd_core
  import pcd_pkg::*;
#(
  parameter int unsigned PHASE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               div_o,
  output logic               run_o
);
  logic               armed_q, run_q, div_q;
  logic [PHASE_W-1:0] dly_q;
  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] hi_len;
  logic               wrap;

  assign hi_len = ratio_i >> 1;
  assign wrap   = (cnt_q == ratio_i - RATIO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      div_q   <= 1'b0;
      dly_q   <= '0;
      cnt_q   <= '0;
    end else if (sync_i) begin
      armed_q <= 1'b1;
      run_q   <= 1'b0;
      div_q   <= 1'b0;
      dly_q   <= phase_i;
      cnt_q   <= '0;
    end else if (armed_q) begin
      run_q <= 1'b1;
      if (dly_q != '0) begin
        dly_q <= dly_q - PHASE_W'(1);
        div_q <= 1'b0;
      end else begin
        div_q <= (cnt_q < hi_len);
        cnt_q <= wrap ? '0 : cnt_q + RATIO_W'(1);
      end
    end
  end

  assign div_o = div_q;
  assign run_o = run_q;

  a_r7_sync_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (!div_q && !run_q && cnt_q == '0));

  a_r5_low_while_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && dly_q != '0) |=> !div_q);

  a_r3_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < ratio_i));

  a_r10_run_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !sync_i) |=> run_q);
endmodule

// File: rtl/pcd_bypass.sv
module pcd_bypass
  import pcd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               clk_o
);
  logic en_q;

  // enable changes while clk_i is low, so the AND cannot glitch
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= run_i && (ratio_i == RATIO_W'(1));
  end

  assign clk_o = clk_i & en_q;

  a_r8_gate_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> (run_i && ratio_i == RATIO_W'(1)));
endmodule

// File: rtl/phase_clk_div.sv
module phase_clk_div
  import pcd_pkg::*;
#(
  parameter int unsigned PHASE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_i,
  input  logic [STRAP_W-1:0] strap_lo_i,
  input  logic [STRAP_W-1:0] strap_hi_i,
  input  logic               table_sel_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic               clk_o,
  output logic               running_o
);
  logic [RATIO_W-1:0] ratio;
  logic               div_clk, byp_clk, run;

  pcd_cfg i_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .strap_lo_i (strap_lo_i),
    .strap_hi_i (strap_hi_i),
    .table_sel_i(table_sel_i),
    .ratio_o    (ratio)
  );

  pcd_core #(.PHASE_W(PHASE_W)) i_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .phase_i(phase_i),
    .ratio_i(ratio),
    .div_o  (div_clk),
    .run_o  (run)
  );

  pcd_bypass i_bypass (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .ratio_i(ratio),
    .clk_o  (byp_clk)
  );

  // divider path is idle at ratio 1, so an OR replaces a clock mux
  assign clk_o     = byp_clk | div_clk;
  assign running_o = run;

  a_r11_reset_quiet: assert property (@(posedge clk_i) !rst_ni |-> (!running_o && !div_clk));
endmodule

// File: tb/test_phase_clk_div.sv
module test_phase_clk_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync = 1'b0;
  logic [1:0] s_lo = '0, s_hi = '0;
  logic       tsel = 1'b0;
  logic [3:0] phase = '0;
  logic       clk_out, running;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  phase_clk_div i_phase_clk_div (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .strap_lo_i(s_lo), .strap_hi_i(s_hi),
    .table_sel_i(tsel), .phase_i(phase), .clk_o(clk_out), .running_o(running)
  );

  int tbl0[16] = '{1,2,3,4,5,6,8,9,10,12,15,16,18,24,30,32};
  int tbl1[16] = '{7,11,13,14,17,19,20,21,22,23,25,26,27,28,29,31};

  function automatic int ratio_of(bit alt, int idx);
    return alt ? tbl1[idx] : tbl0[idx];
  endfunction

  // reference model state
  int  m_n = 2, m_p = 0, m_k = 0;
  bit  m_armed = 0, m_run = 0, m_div = 0, m_byp = 0, m_alt = 0, m_sync = 0;
  bit  r9_win = 0;

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s t=%0t act=%0d exp=%0d (N=%0d P=%0d)", tag, $time, act, exp, m_n, m_p);
    end
  endtask

  function automatic string cur_tag();
    if (!rst_n) return "R11";
    if (m_sync) return "R7";
    if (r9_win) return "R9";
    if (m_n == 1) return "R8";
    if (m_k <= m_p) return "R5";
    if (m_p >= m_n) return "R6";
    return m_alt ? "R2" : "R1";
  endfunction

  always @(posedge clk) begin
    m_sync = sync;
    if (!rst_n) begin
      m_armed = 0; m_run = 0; m_div = 0; m_k = 0;
    end else if (sync) begin
      m_armed = 1; m_run = 0; m_div = 0; m_k = 0;
      m_n = ratio_of(tsel, {s_hi, s_lo}); m_p = phase; m_alt = tsel;
    end else if (m_armed) begin
      int t;
      m_run = 1;
      t = m_k - m_p;
      m_div = (t >= 0) && ((t % m_n) < m_n / 2);
      m_k++;
    end
    #1;
    if (rst_n) begin
      check(cur_tag(), clk_out, m_byp | m_div);
      check("R10", running, m_run);
    end
  end

  always @(negedge clk) begin
    m_byp = rst_n && m_run && (m_n == 1);
    #1;
    if (rst_n) check(m_n == 1 ? "R8" : cur_tag(), clk_out, m_div);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_cfg(bit alt, int idx, int ph);
    int n, hi;
    n = ratio_of(alt, idx);
    @(negedge clk);
    tsel = alt; s_lo = 2'(idx % 4); s_hi = 2'(idx / 4); phase = 4'(ph); sync = 1;
    cyc(2);
    sync = 0;
    cyc(ph + 1);
    if (n > 1) begin
      hi = 0;
      for (int i = 0; i < n; i++) begin
        @(posedge clk); #1;
        hi += int'(clk_out);
      end
      check((n % 2 == 0) ? "R3" : "R4", hi, n / 2);
      cyc(n + 2);
    end else cyc(6);
  endtask

  initial begin
    cyc(3);
    check("R11", clk_out, 0);
    check("R11", running, 0);
    @(negedge clk); rst_n = 1;
    cyc(4);
    check("R10", running, 0);
    for (int a = 0; a < 2; a++)
      for (int i = 0; i < 16; i++) begin
        int n;
        n = ratio_of(a[0], i);
        run_cfg(a[0], i, 0);
        run_cfg(a[0], i, 5);
        run_cfg(a[0], i, 15);
        if (n <= 15) run_cfg(a[0], i, n);
      end
    // R9: change configuration without sync
    @(negedge clk);
    tsel = 0; s_lo = 2'd3; s_hi = 2'd0; phase = 4'd1; sync = 1;
    cyc(2); sync = 0;
    cyc(10);
    r9_win = 1;
    tsel = 1; s_lo = 2'd2; s_hi = 2'd3; phase = 4'd9;
    cyc(20);
    r9_win = 0;
    // R8 then re-sync to a divided ratio
    run_cfg(0, 0, 7);
    @(negedge clk); tsel = 0; s_lo = 2'd1; s_hi = 2'd0; phase = 4'd2; sync = 1;
    cyc(3); sync = 0;
    cyc(12);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule